// File: doc/BRIEF.md
# Stacked-Carrier Multilevel PWM Modulator

This block produces the level command for one phase of an odd-level inverter. It compares a sampled digital sine reference with a stack of LEVELS-1 triangular carriers. Each carrier lives in its own voltage band, and the bands tile the full signed range with no gaps. The result is a signed level index from -(LEVELS-1)/2 to +(LEVELS-1)/2. The block also gives one compare bit for each carrier. A gate decoder further down the chain turns that index into switch states.

The reference is first multiplied by a modulation-index scale word. One shared up/down counter sets where every carrier sits inside its band. A two-bit select picks how the carriers are phased against each other: all in step, mirrored about zero, or flipped on every other band. A new carrier amplitude or a new phase arrangement is accepted only at the bottom of a carrier period. This keeps any carrier from jumping in the middle of a period.

Top module: `stacked_carrier_pwm`

## Requirements
- R1: The registered `level` equals the number of set bits in `band_cmp` minus HALF, where HALF = (LEVELS-1)/2. With a reference above every band the output is +HALF with all bits set, and with a reference below every band it is -HALF with no bits set.
- R2: Bit k of `band_cmp` is 1 exactly when the scaled reference is strictly greater than the value of carrier k. Carrier k ranges over [(k-HALF)*P, (k-HALF+1)*P], so the bits always form a thermometer code that fills from bit 0 upward.
- R3: The shared carrier count starts at 0, rises by one each clock to the active amplitude P, then falls by one each clock back to 0, which gives a period of 2*P clocks. A `carrier_peak` of 0 is treated as 1.
- R4: With select 2'b00, every carrier equals its band floor plus the count, so all carriers are in phase.
- R5: With select 2'b01, carriers below zero (k < HALF) take the inverted form, band floor plus P minus the count. Carriers at or above zero take the normal form.
- R6: With select 2'b10, carriers with odd index k take the inverted form and carriers with even index take the normal form.
- R7: Select 2'b11 behaves the same as 2'b00.
- R8: `disp_sel` and `carrier_peak` are sampled only on a clock where the count is 0 and rising. They govern comparisons from the next clock onward, and changes made at any other time have no effect until the next such clock.
- R9: The scaled reference equals floor(`ref_in` * `mod_idx` / 2^(MI_W-1)), so a `mod_idx` of 2^(MI_W-1) is unity gain.
- R10: Reset is synchronous and active-low. It sets the count to 0 and rising, P to 1 and the arrangement to in-phase, and it drives `level` to -HALF and `band_cmp` to 0. After reset each output reflects the inputs and carrier state of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | REF_W | Signed sampled reference |
| mod_idx | input | MI_W | Unsigned scale, 2^(MI_W-1) is unity |
| carrier_peak | input | CW | Carrier amplitude P in count steps (0 treated as 1) |
| disp_sel | input | 2 | Carrier arrangement: 00 in phase, 01 mirrored about zero, 10 alternating, 11 in phase |
| level | output | LW | Signed level command |
| band_cmp | output | LEVELS-1 | One compare bit per carrier band |

## Verification
The checker watches several properties on every clock. It checks that the level agrees with the population count of the compare bits and that those bits stay a thermometer code. It checks that the carrier count moves by exactly one step and never leaves the range 0 to P. It also checks that the active arrangement changes only after a zero count and that the first outputs after reset are the floor level. The bench scenarios are needed for the rest. Only they can show that each arrangement inverts the correct bands, that the scale arithmetic rounds toward minus infinity, that a zero amplitude acts as one, and that a mid-period change of select or amplitude is held back until the boundary.

// File: rtl/scpwm_pkg.sv
// Shared types for the stacked-carrier modulator.
// Assumes an odd level count; band index 0 is the lowest band.
package scpwm_pkg;

    typedef enum logic [1:0] {
        ARR_INPHASE = 2'b00,
        ARR_MIRROR  = 2'b01,
        ARR_ALTERN  = 2'b10,
        ARR_SPARE   = 2'b11
    } arrange_e;

    // True when band k takes the falling (inverted) carrier shape.
    function automatic logic band_inverted(arrange_e arr, int k, int half);
        case (arr)
            ARR_MIRROR: band_inverted = (k < half);
            ARR_ALTERN: band_inverted = (k % 2) == 1;
            default:    band_inverted = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/scpwm_carrier.sv
// Shared triangular carrier counter.
// Counts 0 -> P -> 0 one step per clock. Amplitude and arrangement are
// captured only when the count sits at 0 on its way up.
// Assumes CW >= 1; an amplitude request of 0 is forced to 1.
module scpwm_carrier #(
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        peak_in,
    input  scpwm_pkg::arrange_e  arr_in,
    output logic [CW-1:0]        cnt,
    output logic [CW-1:0]        peak_q,
    output scpwm_pkg::arrange_e  arr_q
);
    import scpwm_pkg::*;

    logic          falling;
    logic          at_base;
    logic [CW-1:0] pk_eff;
    logic [CW-1:0] cnt_inc;

    // Detect the period boundary and pick the amplitude governing this step.
    always_comb begin
        at_base = (cnt == '0) && !falling;
        pk_eff  = peak_q;
        if (at_base) begin
            pk_eff = (peak_in == '0) ? CW'(1) : peak_in;
        end
        cnt_inc = cnt + CW'(1);
    end

    // Advance the triangle and capture settings at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            falling <= 1'b0;
            peak_q  <= CW'(1);
            arr_q   <= ARR_INPHASE;
        end else begin
            if (at_base) begin
                peak_q <= pk_eff;
                arr_q  <= arr_in;
            end
            if (!falling) begin
                cnt <= cnt_inc;
                if (cnt_inc >= pk_eff) falling <= 1'b1;
            end else begin
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) falling <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/scpwm_bands.sv
// Per-band carrier value and comparison against the scaled reference.
// Band k spans [(k-HALF)*P, (k-HALF+1)*P]; the arrangement decides whether
// the carrier in that band rises or falls with the shared count.
// Assumes DW is wide enough for both the reference and HALF*P.
module scpwm_bands #(
    parameter int NC = 6,
    parameter int CW = 8,
    parameter int DW = 22
) (
    input  logic signed [DW-1:0] scaled,
    input  logic [CW-1:0]        cnt,
    input  logic [CW-1:0]        peak,
    input  scpwm_pkg::arrange_e  arr,
    output logic [NC-1:0]        above
);
    localparam int HALF = NC / 2;

    logic signed [DW-1:0] pk_s;
    logic signed [DW-1:0] cnt_s;

    assign pk_s  = {{(DW-CW){1'b0}}, peak};
    assign cnt_s = {{(DW-CW){1'b0}}, cnt};

    for (genvar k = 0; k < NC; k++) begin : g_band
        localparam logic signed [DW-1:0] OFS = DW'(k - HALF);
        logic                 inv;
        logic signed [DW-1:0] val;

        // Form this band's carrier value and compare.
        always_comb begin
            inv      = scpwm_pkg::band_inverted(arr, k, HALF);
            val      = pk_s * OFS + (inv ? (pk_s - cnt_s) : cnt_s);
            above[k] = scaled > val;
        end
    end
endmodule

// File: rtl/scpwm_level.sv
// Output register: compare bits and their count turned into a signed level.
// Assumes NC is even (odd level count).
module scpwm_level #(
    parameter int NC = 6,
    parameter int LW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NC-1:0]        above,
    output logic [NC-1:0]        cmp_q,
    output logic signed [LW-1:0] level_q
);
    localparam logic signed [LW-1:0] HALF_S = LW'(NC / 2);

    logic [LW-1:0] ones;

    // Count how many carriers the reference exceeds.
    always_comb begin
        ones = '0;
        for (int i = 0; i < NC; i++) ones = ones + LW'(above[i]);
    end

    // Register the comparison result and the offset level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q   <= '0;
            level_q <= -HALF_S;
        end else begin
            cmp_q   <= above;
            level_q <= $signed(ones) - HALF_S;
        end
    end
endmodule

// File: rtl/stacked_carrier_pwm.sv
// Multilevel modulator top: scales the reference, runs the shared carrier,
// compares against every band and registers the level command.
// Assumes LEVELS is odd and at least 3, and mod_idx uses 2^(MI_W-1) as unity.
module stacked_carrier_pwm #(
    parameter  int LEVELS = 7,
    parameter  int REF_W  = 12,
    parameter  int MI_W   = 8,
    parameter  int CW     = 8,
    localparam int NC     = LEVELS - 1,
    localparam int LW     = $clog2(NC + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_in,
    input  logic [MI_W-1:0]         mod_idx,
    input  logic [CW-1:0]           carrier_peak,
    input  logic [1:0]              disp_sel,
    output logic signed [LW-1:0]    level,
    output logic [NC-1:0]           band_cmp
);
    import scpwm_pkg::*;

    localparam int PW = REF_W + MI_W + 1;
    localparam int DW = PW + 1;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] prod_sh;
    logic signed [DW-1:0] scaled;
    logic [CW-1:0]        cnt_w;
    logic [CW-1:0]        peak_w;
    arrange_e             arr_w;
    logic [NC-1:0]        above_w;

    // Apply the modulation index with floor rounding.
    always_comb begin
        prod    = ref_in * $signed({1'b0, mod_idx});
        prod_sh = prod >>> (MI_W - 1);
        scaled  = {prod_sh[PW-1], prod_sh};
    end

    scpwm_carrier #(.CW(CW)) u_carrier (
        .clk     (clk),
        .rst_n   (rst_n),
        .peak_in (carrier_peak),
        .arr_in  (arrange_e'(disp_sel)),
        .cnt     (cnt_w),
        .peak_q  (peak_w),
        .arr_q   (arr_w)
    );

    scpwm_bands #(.NC(NC), .CW(CW), .DW(DW)) u_bands (
        .scaled (scaled),
        .cnt    (cnt_w),
        .peak   (peak_w),
        .arr    (arr_w),
        .above  (above_w)
    );

    scpwm_level #(.NC(NC), .LW(LW)) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .above   (above_w),
        .cmp_q   (band_cmp),
        .level_q (level)
    );
endmodule

// File: rtl/stacked_carrier_pwm_chk.sv
// Property checker for the stacked-carrier modulator, bound to the top.
// Observes the outputs and the shared carrier state.
module stacked_carrier_pwm_chk #(
    parameter int NC = 6,
    parameter int CW = 8,
    parameter int LW = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CW-1:0]        cnt_w,
    input logic [CW-1:0]        peak_w,
    input logic [1:0]           arr_w,
    input logic [NC-1:0]        band_cmp,
    input logic signed [LW-1:0] level
);
    localparam logic signed [LW-1:0] HALF_S = LW'(NC / 2);

    assert_level_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level == $signed(LW'($countones(band_cmp))) - HALF_S);

    assert_thermometer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((band_cmp >> 1) & ~band_cmp) == '0);

    assert_carrier_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_w <= peak_w) && (peak_w != '0));

    assert_carrier_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt_w == $past(cnt_w) + CW'(1)) || (cnt_w == $past(cnt_w) - CW'(1)));

    assert_arrange_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_w != $past(arr_w)) |-> ($past(cnt_w) == '0));

    assert_peak_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (peak_w != $past(peak_w)) |-> ($past(cnt_w) == '0));

    assert_reset_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (level == -HALF_S) && (band_cmp == '0));
endmodule

bind stacked_carrier_pwm stacked_carrier_pwm_chk #(.NC(NC), .CW(CW), .LW(LW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_w    (cnt_w),
    .peak_w   (peak_w),
    .arr_w    (arr_w),
    .band_cmp (band_cmp),
    .level    (level)
);

// File: tb/stacked_carrier_pwm_test.sv
`timescale 1ns/1ps
module stacked_carrier_pwm_test;
    localparam int LEVELS = 7;
    localparam int NC     = LEVELS - 1;
    localparam int HALF   = NC / 2;
    localparam int LW     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic signed [11:0] ref_in = '0;
    logic [7:0]        mod_idx = 8'd128;
    logic [7:0]        carrier_peak = 8'd1;
    logic [1:0]        disp_sel = 2'b00;
    logic signed [LW-1:0] level;
    logic [NC-1:0]     band_cmp;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Requirement-level model of the expected outputs.
    int            m_cnt, m_pk, m_mode;
    bit            m_fall;
    logic [NC-1:0] e_cmp;
    int            e_level;

    always #2 clk = ~clk;

    stacked_carrier_pwm uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .mod_idx(mod_idx),
        .carrier_peak(carrier_peak), .disp_sel(disp_sel),
        .level(level), .band_cmp(band_cmp)
    );

    always @(posedge clk) begin
        int sc, v, pk, ones;
        bit inv, base;
        logic [NC-1:0] b;
        if (!rst_n) begin
            m_cnt <= 0; m_fall <= 0; m_pk <= 1; m_mode <= 0;
            e_cmp <= '0; e_level <= -HALF;
        end else begin
            sc = (int'(ref_in) * int'(mod_idx)) >>> 7;        // R9
            ones = 0;
            for (int k = 0; k < NC; k++) begin
                inv = (m_mode == 1) ? (k < HALF) :               // R5
                      (m_mode == 2) ? (k % 2 == 1) : 1'b0;        // R6, R4, R7
                v = (k - HALF) * m_pk + (inv ? (m_pk - m_cnt) : m_cnt);
                b[k] = sc > v;                                    // R2
                ones += int'(b[k]);
            end
            e_cmp   <= b;
            e_level <= ones - HALF;                               // R1
            base = (m_cnt == 0) && !m_fall;                       // R8
            pk = base ? ((carrier_peak == 0) ? 1 : int'(carrier_peak)) : m_pk;
            if (base) begin m_pk <= pk; m_mode <= int'(disp_sel); end
            if (!m_fall) begin                                    // R3
                m_cnt <= m_cnt + 1;
                if (m_cnt + 1 >= pk) m_fall <= 1;
            end else begin
                m_cnt <= m_cnt - 1;
                if (m_cnt == 1) m_fall <= 0;
            end
        end
    end

    task automatic check_cycle(string tag);
        @(negedge clk);
        n_chk++;
        if (int'(level) !== e_level || band_cmp !== e_cmp) begin
            n_fail++;
            $display("FAIL %s: level=%0d cmp=%b expected level=%0d cmp=%b",
                     tag, level, band_cmp, e_level, e_cmp);
        end
        n_chk++;
        if (int'(level) != $countones(band_cmp) - HALF) begin
            n_fail++;
            $display("FAIL R1: level=%0d expected %0d", level, $countones(band_cmp) - HALF);
        end
    endtask

    task automatic check_literal(string tag, int exp_lvl, logic [NC-1:0] exp_cmp);
        @(negedge clk);
        n_chk++;
        if (int'(level) !== exp_lvl || band_cmp !== exp_cmp) begin
            n_fail++;
            $display("FAIL %s: level=%0d cmp=%b expected level=%0d cmp=%b",
                     tag, level, band_cmp, exp_lvl, exp_cmp);
        end
    endtask

    task automatic run_sweep(int start, int step, int n, string tag);
        for (int i = 0; i < n; i++) begin
            ref_in = 12'(start + i * step);
            check_cycle(tag);
        end
    endtask

    task automatic t_reset_R10();
        rst_n = 1'b0;
        ref_in = 12'sd2000;
        repeat (2) check_literal("R10 reset", -HALF, '0);
        rst_n = 1'b1;
        check_literal("R10 first edge", -HALF + NC, '1);
    endtask

    task automatic t_inphase_R4();
        carrier_peak = 8'd20; disp_sel = 2'b00; mod_idx = 8'd128;
        run_sweep(-70, 3, 50, "R4 in-phase");
    endtask

    task automatic t_mirror_R5();
        disp_sel = 2'b01;
        run_sweep(70, -3, 50, "R5 mirrored");
    endtask

    task automatic t_altern_R6();
        disp_sel = 2'b10; carrier_peak = 8'd9;
        run_sweep(-30, 1, 60, "R6 alternating");
    endtask

    task automatic t_spare_R7();
        disp_sel = 2'b11;
        run_sweep(-30, 2, 30, "R7 spare code");
    endtask

    task automatic t_scale_R9();
        disp_sel = 2'b00; carrier_peak = 8'd12; mod_idx = 8'd64;
        run_sweep(-81, 5, 36, "R9 half scale");
        mod_idx = 8'd200;
        run_sweep(-41, 3, 30, "R9 over scale");
        mod_idx = 8'd128;
    endtask

    task automatic t_peak_R3();
        carrier_peak = 8'd0; disp_sel = 2'b10;
        run_sweep(-4, 1, 10, "R3 zero peak");
        carrier_peak = 8'd1;
        run_sweep(-3, 1, 8, "R3 unit peak");
        carrier_peak = 8'd255;
        run_sweep(-800, 3, 600, "R3 max peak");
    endtask

    task automatic t_switch_R8();
        carrier_peak = 8'd16; disp_sel = 2'b00;
        ref_in = 12'sd5;
        repeat (40) check_cycle("R8 settle");
        for (int j = 0; j < 3; j++) begin
            repeat (7) check_cycle("R8 before change");
            disp_sel = 2'((j + 1) % 3);
            carrier_peak = 8'(6 + 4 * j);
            repeat (45) check_cycle("R8 held to boundary");
        end
    endtask

    task automatic t_extremes_R1();
        disp_sel = 2'b01; carrier_peak = 8'd30;
        ref_in = 12'sd2047;
        check_cycle("R1 settle");
        repeat (3) check_literal("R1 top", HALF, '1);
        ref_in = -12'sd2048;
        check_cycle("R1 settle");
        repeat (3) check_literal("R1 bottom", -HALF, '0);
    endtask

    initial begin
        @(negedge clk);
        t_reset_R10();
        t_inphase_R4();
        t_mirror_R5();
        t_altern_R6();
        t_spare_R7();
        t_scale_R9();
        t_peak_R3();
        t_switch_R8();
        t_extremes_R1();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule